// File: doc/BRIEF.md
# Dual-Path ADC Conversion Sequencer

This block is the digital controller for a two-path, simultaneous-sampling analog-to-digital converter. Eight analog inputs are split into two groups of four. Inputs 0 to 3 reach sample/hold path A through a multiplexer, and inputs 4 to 7 reach path B. One shared select drives both multiplexers, so the block always converts inputs in pairs (0 with 4, 1 with 5, 2 with 6, 3 with 7). A start event is taken from one of several request lines. The block then steps the select through the four pairs and issues one hold strobe per converter clock period.

The converter clock is divided down from the system clock by a programmable ratio between 4 and 30. The analog core is pipelined, so each pair's result comes back several converter clocks after its strobe. The core returns results in strobe order. The block stores each returning pair into two of eight 14-bit result registers, which can be read through an address port. Each stored result is checked against the two end codes of the range, and a hit sets a sticky per-input flag. When all eight results have been stored, the block raises a completion pulse and a held interrupt line. A request that arrives during a sequence does not start a new one and sets an overrun flag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Reset state: after reset, busy, done, irq, overrun, sha_strobe, mux_sel and oor_flags are all zero, and every result register reads as zero.
- R2: After a start is accepted, exactly four sha_strobe pulses follow, each one system cycle wide, with mux_sel equal to 0, 1, 2, 3 in that order. mux_sel is already stable in the cycle before each pulse, and successive pulses are one converter clock period apart.
- R3: The adc_clk period is N system cycles, and adc_clk is high for floor(N/2) of them. N is div_sel clamped to the range 4 to 30 (values below 4 give 4, values above 30 give 30).
- R4: Only start_req[start_sel] can start a sequence. A high level on any other start_req bit has no effect.
- R5: The k-th core_valid pulse of a sequence (k = 0..3) stores core_a_data into result register k and core_b_data into result register k+4. rd_data shows result register rd_addr in the same cycle.
- R6: oor_flags bit i is set when result i is stored with the value 0 or 16383 (0x3FFF, unsigned). The flags are sticky for the rest of the sequence and are cleared only when a new start is accepted.
- R7: A selected start request that arrives while busy is high is ignored: the running sequence still gives exactly four strobes and its own results. Such a request sets overrun, which stays high until the next accepted start clears it.
- R8: In the same clock edge that stores the fourth pair of results, done goes high for exactly one cycle, irq goes high, and busy drops. irq stays high until the next accepted start clears it.
- R9: busy goes high in the cycle after a selected start request is seen while idle, and stays high until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 5 | Converter clock divide ratio, clamped to 4..30 |
| start_sel | input | 2 | Index of the start request line that is obeyed |
| start_req | input | 4 | Start request lines, active high |
| mux_sel | output | 2 | Pair select shared by both input multiplexers |
| sha_strobe | output | 1 | Hold strobe for both sample/hold paths |
| adc_clk | output | 1 | Converter clock |
| core_valid | input | 1 | Core result pair valid, one cycle |
| core_a_data | input | 14 | Path A result |
| core_b_data | input | 14 | Path B result |
| rd_addr | input | 3 | Result register read address |
| rd_data | output | 14 | Selected result register |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Completion interrupt, held |
| overrun | output | 1 | Start request seen while busy |
| oor_flags | output | 8 | Per-input out-of-range flags |

## Verification
The assertions assume that div_sel does not change during a sequence, and that core_valid arrives only for strobes that were issued, once per strobe and in strobe order. The checks on converter clock width also assume that the clock ratio has settled. The bench core stub produces results only from the strobes it has observed, using a six-stage pipeline that advances on adc_clk rising edges. The bench changes div_sel only while the block is idle and after waiting at least one full converter period. Requests that are deliberately ignored are driven only on unselected lines or while a sequence is already running.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int unsigned DATA_W   = 14;
    localparam int unsigned N_PAIRS  = 4;
    localparam int unsigned DIV_LO   = 4;
    localparam int unsigned DIV_HI   = 30;
    localparam int unsigned N_SRC    = 4;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SAMPLE = 2'd1,
        SQ_DRAIN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int unsigned DIV_LO = 4,
    parameter int unsigned DIV_HI = 30,
    localparam int unsigned CW    = $clog2(DIV_HI + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] div_sel,
    output logic          tick,
    output logic          aclk
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          aclk;
    } div_t;

    div_t q, d;
    logic [CW-1:0] ratio;
    logic [CW-1:0] half;

    always_comb begin
        if (div_sel < CW'(DIV_LO))      ratio = CW'(DIV_LO);
        else if (div_sel > CW'(DIV_HI)) ratio = CW'(DIV_HI);
        else                            ratio = div_sel;
        half   = ratio >> 1;
        d      = q;
        d.cnt  = (q.cnt >= ratio - CW'(1)) ? '0 : q.cnt + CW'(1);
        d.aclk = (d.cnt < half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= CW'(DIV_HI);
            q.aclk <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign tick = (q.cnt == '0);
    assign aclk = q.aclk;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned PAIRS = 4,
    localparam int unsigned PW   = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start_hit,
    input  logic          res_valid,
    output logic [PW-1:0] pair_sel,
    output logic          strobe,
    output logic          cap_en,
    output logic [PW-1:0] cap_slot,
    output logic          clr,
    output logic          busy,
    output logic          done,
    output logic          irq,
    output logic          ovr
);
    localparam logic [PW-1:0] LAST = PW'(PAIRS - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [PW-1:0] idx;
        logic [PW-1:0] got;
        logic          strobe;
        logic          done;
        logic          irq;
        logic          ovr;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        clr    = 1'b0;
        cap_en = 1'b0;
        if (q.state == SQ_IDLE) begin
            if (start_hit) begin
                d.state = SQ_SAMPLE;
                d.idx   = '0;
                d.got   = '0;
                d.irq   = 1'b0;
                d.ovr   = 1'b0;
                clr     = 1'b1;
            end
        end else begin
            if (start_hit) d.ovr = 1'b1;
            if (q.state == SQ_SAMPLE) begin
                if (q.strobe) begin
                    d.strobe = 1'b0;
                    if (q.idx == LAST) d.state = SQ_DRAIN;
                    else               d.idx   = q.idx + PW'(1);
                end else if (tick) begin
                    d.strobe = 1'b1;
                end
            end
            if (res_valid) begin
                cap_en = 1'b1;
                if (q.got == LAST) begin
                    d.state  = SQ_IDLE;
                    d.done   = 1'b1;
                    d.irq    = 1'b1;
                    d.idx    = '0;
                    d.strobe = 1'b0;
                end else begin
                    d.got = q.got + PW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= SQ_IDLE;
            q.idx    <= '0;
            q.got    <= '0;
            q.strobe <= 1'b0;
            q.done   <= 1'b0;
            q.irq    <= 1'b0;
            q.ovr    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pair_sel = q.idx;
    assign strobe   = q.strobe;
    assign cap_slot = q.got;
    assign busy     = (q.state != SQ_IDLE);
    assign done     = q.done;
    assign irq      = q.irq;
    assign ovr      = q.ovr;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int unsigned DW    = 14,
    parameter int unsigned PAIRS = 4,
    localparam int unsigned CH   = 2 * PAIRS,
    localparam int unsigned CHW  = $clog2(CH),
    localparam int unsigned PW   = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           cap_en,
    input  logic [PW-1:0]  cap_slot,
    input  logic [DW-1:0]  a_data,
    input  logic [DW-1:0]  b_data,
    input  logic [CHW-1:0] rd_addr,
    output logic [DW-1:0]  rd_data,
    output logic [CH-1:0]  oor
);
    localparam logic [DW-1:0] CODE_MAX = {DW{1'b1}};

    typedef struct packed {
        logic [CH-1:0][DW-1:0] res;
        logic [CH-1:0]         flg;
    } bank_t;

    bank_t q, d;

    function automatic logic at_edge(input logic [DW-1:0] v);
        return (v == '0) || (v == CODE_MAX);
    endfunction

    always_comb begin
        d = q;
        if (clr) d.flg = '0;
        for (int p = 0; p < int'(PAIRS); p++) begin
            if (cap_en && cap_slot == PW'(p)) begin
                d.res[p]         = a_data;
                d.res[p + PAIRS] = b_data;
                if (at_edge(a_data)) d.flg[p]         = 1'b1;
                if (at_edge(b_data)) d.flg[p + PAIRS] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data = q.res[rd_addr];
    assign oor     = q.flg;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned DW     = DATA_W,
    parameter int unsigned PAIRS  = N_PAIRS,
    parameter int unsigned DIV_MIN = DIV_LO,
    parameter int unsigned DIV_MAX = DIV_HI,
    parameter int unsigned NSRC   = N_SRC,
    localparam int unsigned CH    = 2 * PAIRS,
    localparam int unsigned CHW   = $clog2(CH),
    localparam int unsigned PW    = (PAIRS > 1) ? $clog2(PAIRS) : 1,
    localparam int unsigned SW    = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int unsigned CW    = $clog2(DIV_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  div_sel,
    input  logic [SW-1:0]  start_sel,
    input  logic [NSRC-1:0] start_req,
    output logic [PW-1:0]  mux_sel,
    output logic           sha_strobe,
    output logic           adc_clk,
    input  logic           core_valid,
    input  logic [DW-1:0]  core_a_data,
    input  logic [DW-1:0]  core_b_data,
    input  logic [CHW-1:0] rd_addr,
    output logic [DW-1:0]  rd_data,
    output logic           busy,
    output logic           done,
    output logic           irq,
    output logic           overrun,
    output logic [CH-1:0]  oor_flags
);
    logic          tick;
    logic          start_hit;
    logic          cap_en;
    logic          clr;
    logic [PW-1:0] cap_slot;

    assign start_hit = start_req[start_sel];

    adc_clk_div #(.DIV_LO(DIV_MIN), .DIV_HI(DIV_MAX)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .tick    (tick),
        .aclk    (adc_clk)
    );

    adc_seq_fsm #(.PAIRS(PAIRS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start_hit (start_hit),
        .res_valid (core_valid),
        .pair_sel  (mux_sel),
        .strobe    (sha_strobe),
        .cap_en    (cap_en),
        .cap_slot  (cap_slot),
        .clr       (clr),
        .busy      (busy),
        .done      (done),
        .irq       (irq),
        .ovr       (overrun)
    );

    adc_result_bank #(.DW(DW), .PAIRS(PAIRS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .cap_en   (cap_en),
        .cap_slot (cap_slot),
        .a_data   (core_a_data),
        .b_data   (core_b_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .oor      (oor_flags)
    );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int unsigned PW   = 2,
    parameter int unsigned SW   = 2,
    parameter int unsigned NSRC = 4,
    parameter int unsigned CH   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [SW-1:0]   start_sel,
    input logic [NSRC-1:0] start_req,
    input logic [PW-1:0]   mux_sel,
    input logic            sha_strobe,
    input logic            adc_clk,
    input logic            busy,
    input logic            done,
    input logic            irq,
    input logic            overrun,
    input logic [CH-1:0]   oor_flags
);
    logic sel_req;
    assign sel_req = start_req[start_sel];

    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sha_strobe |=> !sha_strobe);
    p_strobe_in_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sha_strobe |-> busy);
    p_sel_settled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sha_strobe) |-> $stable(mux_sel));
    p_aclk_min_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_clk) |=> adc_clk);
    p_aclk_min_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_clk) |=> !adc_clk);
    p_flags_fresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (oor_flags == '0));
    p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sel_req) |=> overrun);
    p_overrun_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !overrun);
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (irq && !busy));
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sel_req) |=> busy);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.PW(PW), .SW(SW), .NSRC(NSRC), .CH(CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_sel  (start_sel),
    .start_req  (start_req),
    .mux_sel    (mux_sel),
    .sha_strobe (sha_strobe),
    .adc_clk    (adc_clk),
    .busy       (busy),
    .done       (done),
    .irq        (irq),
    .overrun    (overrun),
    .oor_flags  (oor_flags)
);

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  div_sel = 5'd4;
    logic [1:0]  start_sel = 2'd0;
    logic [3:0]  start_req = '0;
    logic [1:0]  mux_sel;
    logic        sha_strobe, adc_clk;
    logic        core_valid = 1'b0;
    logic [13:0] core_a_data = '0, core_b_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [13:0] rd_data;
    logic        busy, done, irq, overrun;
    logic [7:0]  oor_flags;

    always #2.5 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .start_sel(start_sel),
        .start_req(start_req), .mux_sel(mux_sel), .sha_strobe(sha_strobe),
        .adc_clk(adc_clk), .core_valid(core_valid), .core_a_data(core_a_data),
        .core_b_data(core_b_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .irq(irq), .overrun(overrun),
        .oor_flags(oor_flags)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural core: six-stage pipeline advanced on adc_clk rising edges
    logic [13:0] ch_code [8];
    logic        pv [6];
    logic [1:0]  ps [6];
    logic        pend;
    logic [1:0]  pend_sel;
    logic        aclk_prev;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) begin pv[i] = 0; ps[i] = 0; end
            pend = 0; pend_sel = 0; aclk_prev = 0; core_valid <= 0;
        end else begin
            core_valid <= 0;
            if (adc_clk && !aclk_prev) begin
                if (pv[5]) begin
                    core_valid  <= 1;
                    core_a_data <= ch_code[ps[5]];
                    core_b_data <= ch_code[ps[5] + 4];
                end
                for (int i = 5; i > 0; i--) begin pv[i] = pv[i-1]; ps[i] = ps[i-1]; end
                pv[0] = pend; ps[0] = pend_sel; pend = 0;
            end
            aclk_prev = adc_clk;
            if (sha_strobe) begin pend = 1; pend_sel = mux_sel; end
        end
    end

    // scoreboard
    typedef struct {
        logic [13:0] code [8];
        logic [7:0]  flags;
    } exp_t;
    exp_t sb_q[$];
    int   strobes = 0;
    int   exp_idx = 0;
    int   done_seen = 0;

    always @(negedge clk) begin
        if (rst_n && sha_strobe) begin
            chk(mux_sel == exp_idx[1:0] && exp_idx < 4, "R2 pair order", mux_sel, exp_idx);
            exp_idx++;
            strobes++;
        end
    end

    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            chk(sb_q.size() > 0, "R8 done without queued sequence", sb_q.size(), 1);
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                chk(strobes == 4, "R2/R7 strobe count", strobes, 4);
                chk(irq == 1'b1, "R8 irq with done", irq, 1);
                chk(busy == 1'b0, "R8 busy drops with done", busy, 0);
                chk(oor_flags == e.flags, "R6 out-of-range flags", oor_flags, e.flags);
                for (int i = 0; i < 8; i++) begin
                    rd_addr = 3'(i);
                    #0.2;
                    chk(rd_data == e.code[i], $sformatf("R5 result %0d", i), rd_data, e.code[i]);
                end
            end
            strobes = 0;
            exp_idx = 0;
            done_seen++;
        end
    end

    task automatic pulse_start(input int b);
        @(negedge clk);
        start_req[b] = 1'b1;
        @(negedge clk);
        start_req = '0;
    endtask

    task automatic push_exp(input logic [13:0] c [8]);
        exp_t e;
        e.flags = '0;
        for (int i = 0; i < 8; i++) begin
            e.code[i] = c[i];
            ch_code[i] = c[i];
            if (c[i] == 14'd0 || c[i] == 14'h3FFF) e.flags[i] = 1'b1;
        end
        sb_q.push_back(e);
    endtask

    task automatic run_seq(input logic [13:0] c [8], input int div, input int src);
        int target;
        @(negedge clk);
        div_sel = 5'(div);
        start_sel = 2'(src);
        repeat (32) @(negedge clk);
        push_exp(c);
        target = done_seen + 1;
        pulse_start(src);
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        chk(irq == 1'b0, "R8 irq cleared by start", irq, 0);
        chk(overrun == 1'b0, "R7 overrun cleared by start", overrun, 0);
        chk(oor_flags == 8'h00, "R6 flags cleared by start", oor_flags, 0);
        wait (done_seen == target);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        chk(irq == 1'b1, "R8 irq held", irq, 1);
    endtask

    task automatic measure(input int div, input int exp_n);
        int per, hi;
        @(negedge clk);
        div_sel = 5'(div);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            while (adc_clk) @(negedge clk);
            while (!adc_clk) @(negedge clk);
        end
        per = 0; hi = 0;
        while (adc_clk) begin hi++; per++; @(negedge clk); end
        while (!adc_clk) begin per++; @(negedge clk); end
        chk(per == exp_n, $sformatf("R3 period div_sel=%0d", div), per, exp_n);
        chk(hi == exp_n / 2, $sformatf("R3 high time div_sel=%0d", div), hi, exp_n / 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R8: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [13:0] c [8];
        int target;
        int snap;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && irq == 0, "R1 status idle", {busy, done, irq}, 0);
        chk(overrun == 0 && sha_strobe == 0, "R1 overrun/strobe", {overrun, sha_strobe}, 0);
        chk(oor_flags == 0 && mux_sel == 0, "R1 flags/mux", {oor_flags, mux_sel}, 0);
        for (int i = 0; i < 8; i++) begin
            rd_addr = 3'(i);
            #0.2;
            chk(rd_data == 0, $sformatf("R1 result %0d zero", i), rd_data, 0);
        end

        // R5 plain codes, fastest clock
        for (int i = 0; i < 8; i++) c[i] = 14'(100 * (i + 1) + 7);
        run_seq(c, 4, 0);

        // R6 end codes, slowest clock, last source
        for (int i = 0; i < 8; i++) c[i] = 14'(4000 + 333 * i);
        c[1] = 14'd0; c[6] = 14'h3FFF; c[3] = 14'd1; c[4] = 14'h3FFE;
        run_seq(c, 30, 3);

        // R6 flags cleared by next run
        for (int i = 0; i < 8; i++) c[i] = 14'(9000 - 511 * i);
        run_seq(c, 7, 1);

        // R4 unselected sources ignored
        @(negedge clk);
        start_sel = 2'd2;
        rd_addr = 3'd0;
        #0.2 snap = rd_data;
        pulse_start(0);
        pulse_start(1);
        pulse_start(3);
        repeat (60) @(negedge clk);
        chk(busy == 0, "R4 no start from other lines", busy, 0);
        chk(strobes == 0, "R4 no strobes", strobes, 0);
        chk(irq == 1, "R4 irq untouched", irq, 1);
        rd_addr = 3'd0;
        #0.2;
        chk(rd_data == snap, "R4 results untouched", rd_data, snap);

        // R7 start during a running sequence
        for (int i = 0; i < 8; i++) c[i] = 14'(1234 + 1000 * i);
        c[7] = 14'd0;
        @(negedge clk);
        div_sel = 5'd5;
        start_sel = 2'd2;
        repeat (16) @(negedge clk);
        push_exp(c);
        target = done_seen + 1;
        pulse_start(2);
        chk(overrun == 0, "R7 overrun clear at start", overrun, 0);
        repeat (8) @(negedge clk);
        pulse_start(2);
        chk(overrun == 1, "R7 overrun set", overrun, 1);
        chk(busy == 1, "R7 sequence continues", busy, 1);
        wait (done_seen == target);
        @(negedge clk);
        chk(overrun == 1, "R7 overrun held after done", overrun, 1);
        for (int i = 0; i < 8; i++) c[i] = 14'(555 + 77 * i);
        run_seq(c, 4, 2);

        // R3 divider clamping
        measure(2, 4);
        measure(31, 30);
        measure(9, 9);
        measure(4, 4);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule